// File: doc/BRIEF.md
# Zero-Address Operand Stack with Call/Return Support

This block keeps a last-in first-out operand stack in a small private RAM and drives it from a one-command-per-cycle interface. An internal pointer always names the next free slot. A push therefore writes first and then moves the pointer up. A pop moves the pointer down first and then reads the slot it now names.

On top of plain push and pop, the stack offers three more operations. A zero-address add replaces the two topmost entries with their sum. A call saves a return address (the current program counter plus one) on the stack and hands the call target back as the next program counter. A return pops a saved address and hands it back as the next program counter.

Any operation that would go past either end of the storage is refused. The refusal raises a one-cycle error pulse and leaves the pointer and the stored words untouched.

Top module: `zstack_unit`

## Requirements
- R1: After a synchronous active-high reset, the pointer is 0, `empty` is 1, and `full`, `busy`, `err`, `pop_valid` and `pc_load` are all 0.
- R2: An accepted push (opcode 1) on a non-full stack stores `cmd_data` at the slot the pointer names, and the pointer reads one higher after that clock edge.
- R3: An accepted pop (opcode 2) on a non-empty stack lowers the pointer by one. After the same edge, `pop_valid` is high for one cycle and `pop_data` holds the word at the new top. Values come back in last-in first-out order.
- R4: An accepted add (opcode 3) with at least two entries takes two cycles. `busy` is high for exactly the one cycle after acceptance. At the end of that cycle, the sum modulo 2^DATA_W of the two top entries replaces both of them, and the pointer is one lower than before the add.
- R5: A command presented while `busy` is high is ignored, with no effect on the pointer, the stored words or any output.
- R6: An accepted call (opcode 4) on a non-full stack pushes `pc_cur`+1 (modulo 2^DATA_W). It also presents `cmd_data` on `pc_next`, with `pc_load` high for one cycle after the edge.
- R7: An accepted return (opcode 5) on a non-empty stack pops the top word and presents it on `pc_next`, with `pc_load` high for one cycle after the edge.
- R8: A push or call on a full stack raises `err` for one cycle, leaves the pointer unchanged and writes nothing; the words below stay intact.
- R9: A pop or return on an empty stack, or an add with fewer than two entries, raises `err` for one cycle, leaves the pointer unchanged and produces no `pop_valid` or `pc_load`.
- R10: `full` is 1 exactly when the pointer equals STACK_DEPTH, and `empty` is 1 exactly when the pointer is 0.
- R11: Opcodes 0, 6 and 7, and any cycle with `cmd_valid` low, leave the pointer, the stored words and all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | Opcode: 0 none, 1 push, 2 pop, 3 add, 4 call, 5 return |
| cmd_data | input | DATA_W | Push value or call target |
| pc_cur | input | DATA_W | Current program counter, used by call |
| pop_data | output | DATA_W | Word read by the last pop |
| pop_valid | output | 1 | One-cycle pulse: `pop_data` is fresh |
| pc_next | output | DATA_W | Program counter to load after call or return |
| pc_load | output | 1 | One-cycle pulse: `pc_next` is fresh |
| busy | output | 1 | Add in its second cycle; commands are ignored |
| err | output | 1 | One-cycle pulse: last command was refused |
| full | output | 1 | Pointer equals STACK_DEPTH |
| empty | output | 1 | Pointer equals 0 |
| sp | output | $clog2(STACK_DEPTH+1) | Stack pointer (next free slot) |

## Verification
The hardest states to reach from the ports are the ones where a command lands while the stack sits at a boundary or while an add is still finishing. Examples are a call on a completely full stack, an add with a single entry, and a push arriving in the add's second cycle.

Directed sequences first fill the stack to the top and drain it to the bottom to hit those boundaries. Further sequences then issue commands right after an add. A long weighted random run follows, in which a behavioural queue model is compared with every output on every clock. Refused writes are exposed later, when the untouched entries are popped back out.

// File: rtl/zstk_pkg.sv
`timescale 1ns/1ps
package zstk_pkg;

    typedef enum logic [2:0] {
        OP_IDLE = 3'd0,
        OP_PUSH = 3'd1,
        OP_POP  = 3'd2,
        OP_ADD  = 3'd3,
        OP_CALL = 3'd4,
        OP_RET  = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    typedef enum logic {
        WL_TOP   = 1'b0,
        WL_UNDER = 1'b1
    } wloc_e;

    typedef enum logic {
        ST_READY = 1'b0,
        ST_SUM   = 1'b1
    } state_e;

    function automatic bool_grows(input op_e op);
        return (op == OP_PUSH) || (op == OP_CALL);
    endfunction

    function automatic bool_shrinks(input op_e op);
        return (op == OP_POP) || (op == OP_RET);
    endfunction

endpackage

// File: rtl/zstk_ram.sv
`timescale 1ns/1ps
module zstk_ram #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata_a = cells[raddr_a];
    assign rdata_b = cells[raddr_b];

    always_ff @(posedge clk) begin
        if (we) begin
            assert_waddr_in_range_R8: assert (int'(waddr) < DEPTH)
                else $error("write address outside storage");
        end
    end
endmodule

// File: rtl/zstk_ptr.sv
`timescale 1ns/1ps
module zstk_ptr
    import zstk_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int SP_W = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  step_e           step,
    output logic [SP_W-1:0] sp,
    output logic [AW-1:0]   at_free,
    output logic [AW-1:0]   at_top,
    output logic [AW-1:0]   at_under,
    output logic            full,
    output logic            empty,
    output logic            has_two
);
    localparam logic [SP_W-1:0] LIMIT = SP_W'(DEPTH);

    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= '0;
        end else begin
            unique case (step)
                STEP_UP:   sp <= sp + 1'b1;
                STEP_DOWN: sp <= sp - 1'b1;
                default:   sp <= sp;
            endcase
        end
    end

    always_comb begin
        logic [SP_W-1:0] m1;
        logic [SP_W-1:0] m2;
        m1       = sp - SP_W'(1);
        m2       = sp - SP_W'(2);
        at_free  = sp[AW-1:0];
        at_top   = m1[AW-1:0];
        at_under = m2[AW-1:0];
    end

    assign full    = (sp == LIMIT);
    assign empty   = (sp == '0);
    assign has_two = (sp >= SP_W'(2));

    assert_sp_bound_R10: assert property (@(posedge clk) disable iff (rst)
        sp <= LIMIT);
    assert_no_up_when_full_R8: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_UP) |-> !full);
    assert_no_down_when_empty_R9: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_DOWN) |-> !empty);
endmodule

// File: rtl/zstk_ctrl.sv
`timescale 1ns/1ps
module zstk_ctrl
    import zstk_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [DATA_W-1:0] pc_cur,
    input  logic              full,
    input  logic              empty,
    input  logic              has_two,
    input  logic [DATA_W-1:0] top_word,
    input  logic [DATA_W-1:0] under_word,
    output step_e             step,
    output logic              we,
    output wloc_e             wloc,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] pop_data,
    output logic              pop_valid,
    output logic [DATA_W-1:0] pc_next,
    output logic              pc_load,
    output logic              err,
    output logic              busy
);
    state_e            state;
    logic [DATA_W-1:0] opnd_hi;
    logic [DATA_W-1:0] opnd_lo;
    logic              accept;
    logic              refuse;
    op_e               op;

    assign op     = op_e'(cmd_op);
    assign accept = cmd_valid && (state == ST_READY);
    assign busy   = (state == ST_SUM);

    always_comb begin
        step  = STEP_HOLD;
        we    = 1'b0;
        wloc  = WL_TOP;
        wdata = cmd_data;
        if (state == ST_SUM) begin
            we    = 1'b1;
            wloc  = WL_UNDER;
            wdata = opnd_hi + opnd_lo;
            step  = STEP_DOWN;
        end else if (accept) begin
            if (bool_grows(op) && !full) begin
                we    = 1'b1;
                step  = STEP_UP;
                wdata = (op == OP_CALL) ? pc_cur + 1'b1 : cmd_data;
            end else if (bool_shrinks(op) && !empty) begin
                step = STEP_DOWN;
            end
        end
    end

    always_comb begin
        refuse = 1'b0;
        if (accept) begin
            refuse = (bool_grows(op) && full) ||
                     (bool_shrinks(op) && empty) ||
                     ((op == OP_ADD) && !has_two);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_READY;
            opnd_hi   <= '0;
            opnd_lo   <= '0;
            pop_data  <= '0;
            pop_valid <= 1'b0;
            pc_next   <= '0;
            pc_load   <= 1'b0;
            err       <= 1'b0;
        end else begin
            pop_valid <= 1'b0;
            pc_load   <= 1'b0;
            err       <= refuse;
            if (state == ST_SUM) begin
                state <= ST_READY;
            end else if (accept) begin
                unique case (op)
                    OP_POP: if (!empty) begin
                        pop_valid <= 1'b1;
                        pop_data  <= top_word;
                    end
                    OP_RET: if (!empty) begin
                        pc_load <= 1'b1;
                        pc_next <= top_word;
                    end
                    OP_CALL: if (!full) begin
                        pc_load <= 1'b1;
                        pc_next <= cmd_data;
                    end
                    OP_ADD: if (has_two) begin
                        opnd_hi <= top_word;
                        opnd_lo <= under_word;
                        state   <= ST_SUM;
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_busy_single_R4: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);
    assert_refusal_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({err, pop_valid, pc_load}));
    assert_busy_no_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        busy |=> !err && !pop_valid && !pc_load);
endmodule

// File: rtl/zstack_unit.sv
`timescale 1ns/1ps
module zstack_unit
    import zstk_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int STACK_DEPTH = 16,
    localparam int AW         = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1,
    localparam int SP_W       = $clog2(STACK_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [DATA_W-1:0] pc_cur,
    output logic [DATA_W-1:0] pop_data,
    output logic              pop_valid,
    output logic [DATA_W-1:0] pc_next,
    output logic              pc_load,
    output logic              busy,
    output logic              err,
    output logic              full,
    output logic              empty,
    output logic [SP_W-1:0]   sp
);
    step_e             step;
    logic              we;
    wloc_e             wloc;
    logic [DATA_W-1:0] wdata;
    logic [AW-1:0]     at_free;
    logic [AW-1:0]     at_top;
    logic [AW-1:0]     at_under;
    logic              has_two;
    logic [DATA_W-1:0] top_word;
    logic [DATA_W-1:0] under_word;
    logic [AW-1:0]     waddr;

    assign waddr = (wloc == WL_UNDER) ? at_under : at_free;

    zstk_ptr #(.DEPTH(STACK_DEPTH)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .sp       (sp),
        .at_free  (at_free),
        .at_top   (at_top),
        .at_under (at_under),
        .full     (full),
        .empty    (empty),
        .has_two  (has_two)
    );

    zstk_ram #(.DATA_W(DATA_W), .DEPTH(STACK_DEPTH)) u_ram (
        .clk     (clk),
        .we      (we),
        .waddr   (waddr),
        .wdata   (wdata),
        .raddr_a (at_top),
        .rdata_a (top_word),
        .raddr_b (at_under),
        .rdata_b (under_word)
    );

    zstk_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_data   (cmd_data),
        .pc_cur     (pc_cur),
        .full       (full),
        .empty      (empty),
        .has_two    (has_two),
        .top_word   (top_word),
        .under_word (under_word),
        .step       (step),
        .we         (we),
        .wloc       (wloc),
        .wdata      (wdata),
        .pop_data   (pop_data),
        .pop_valid  (pop_valid),
        .pc_next    (pc_next),
        .pc_load    (pc_load),
        .err        (err),
        .busy       (busy)
    );

    assert_push_grows_R2: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_UP) |=> sp == $past(sp) + 1'b1);
    assert_pop_lowers_R3: assert property (@(posedge clk) disable iff (rst)
        pop_valid |-> sp == $past(sp) - 1'b1);
    assert_add_lowers_R4: assert property (@(posedge clk) disable iff (rst)
        busy |=> sp == $past(sp) - 1'b1);
    assert_refused_sp_kept_R8: assert property (@(posedge clk) disable iff (rst)
        err |-> sp == $past(sp));
endmodule

// File: tb/zstack_unit_tb.sv
`timescale 1ns/1ps
module zstack_unit_tb;
    localparam int DW    = 8;
    localparam int DEPTH = 8;
    localparam int SPW   = $clog2(DEPTH + 1);
    localparam int MASK  = (1 << DW) - 1;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cmd_valid = 1'b0;
    logic [2:0]     cmd_op = 3'd0;
    logic [DW-1:0]  cmd_data = '0;
    logic [DW-1:0]  pc_cur = '0;
    logic [DW-1:0]  pop_data;
    logic           pop_valid;
    logic [DW-1:0]  pc_next;
    logic           pc_load;
    logic           busy;
    logic           err;
    logic           full;
    logic           empty;
    logic [SPW-1:0] sp;

    always #2 clk = ~clk;

    zstack_unit #(.DATA_W(DW), .STACK_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .pc_cur(pc_cur), .pop_data(pop_data),
        .pop_valid(pop_valid), .pc_next(pc_next), .pc_load(pc_load),
        .busy(busy), .err(err), .full(full), .empty(empty), .sp(sp)
    );

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  cmp_on   = 1'b0;
    bit  done     = 1'b0;

    int  q[$];
    bit  m_pend = 0;
    bit  m_pv = 0, m_pl = 0, m_err = 0;
    int  m_pd = 0, m_pn = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            m_pend = 0; m_pv = 0; m_pl = 0; m_err = 0; m_pd = 0; m_pn = 0;
        end else begin
            m_pv = 0; m_pl = 0; m_err = 0;
            if (m_pend) begin
                int a, b;
                a = q.pop_back();
                b = q.pop_back();
                q.push_back((a + b) & MASK);
                m_pend = 0;
            end else if (cmd_valid) begin
                case (cmd_op)
                    3'd1: if (q.size() == DEPTH) m_err = 1; else q.push_back(int'(cmd_data));
                    3'd2: if (q.size() == 0) m_err = 1;
                          else begin m_pd = q.pop_back(); m_pv = 1; end
                    3'd3: if (q.size() < 2) m_err = 1; else m_pend = 1;
                    3'd4: if (q.size() == DEPTH) m_err = 1;
                          else begin q.push_back((int'(pc_cur) + 1) & MASK);
                                     m_pn = int'(cmd_data); m_pl = 1; end
                    3'd5: if (q.size() == 0) m_err = 1;
                          else begin m_pn = q.pop_back(); m_pl = 1; end
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check(int'(sp) == q.size(), "R2", "sp", int'(sp), q.size());
            check(full == (q.size() == DEPTH), "R10", "full", int'(full), int'(q.size() == DEPTH));
            check(empty == (q.size() == 0), "R10", "empty", int'(empty), int'(q.size() == 0));
            check(busy == m_pend, "R4", "busy", int'(busy), int'(m_pend));
            check(err == m_err, "R8", "err", int'(err), int'(m_err));
            check(pop_valid == m_pv, "R3", "pop_valid", int'(pop_valid), int'(m_pv));
            if (m_pv) check(int'(pop_data) == m_pd, "R3", "pop_data", int'(pop_data), m_pd);
            check(pc_load == m_pl, "R6", "pc_load", int'(pc_load), int'(m_pl));
            if (m_pl) check(int'(pc_next) == m_pn, "R7", "pc_next", int'(pc_next), m_pn);
        end
    end

    task automatic cmd(input bit v, input int op, input int d, input int p);
        @(negedge clk);
        cmd_valid = v;
        cmd_op    = 3'(op);
        cmd_data  = DW'(d);
        pc_cur    = DW'(p);
    endtask

    task automatic idle();
        cmd(1'b0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(sp == 0 && empty && !full && !busy && !err && !pop_valid && !pc_load,
              "R1", "reset state", int'(sp), 0);
        cmp_on = 1'b1;
        // R9: refusals on empty stack
        cmd(1, 2, 0, 0); cmd(1, 5, 0, 0); cmd(1, 3, 0, 0);
        cmd(1, 1, 33, 0); cmd(1, 3, 0, 0); idle();      // R9: add with one entry
        cmd(1, 2, 0, 0);
        // R2/R8: fill, then overflow by push and call
        for (int i = 0; i < DEPTH; i++) cmd(1, 1, 10 + i, 0);
        cmd(1, 1, 99, 0); cmd(1, 4, 77, 5); idle();
        // R3: drain shows untouched words in LIFO order
        for (int i = 0; i < DEPTH + 1; i++) cmd(1, 2, 0, 0);
        // R4/R5: add with wrap, command during busy ignored
        cmd(1, 1, 250, 0); cmd(1, 1, 10, 0); cmd(1, 3, 0, 0);
        cmd(1, 1, 123, 0); idle(); cmd(1, 2, 0, 0);
        // R6/R7: call and return
        cmd(1, 4, 200, 255); cmd(1, 4, 40, 17); cmd(1, 5, 0, 0); cmd(1, 5, 0, 0);
        // R11: opcodes 0, 6, 7 and invalid cycles do nothing
        cmd(1, 1, 5, 0); cmd(1, 0, 1, 0); cmd(1, 6, 1, 0); cmd(1, 7, 1, 0);
        cmd(0, 1, 66, 0); cmd(0, 2, 0, 0); cmd(1, 2, 0, 0);
        // random phase
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            cmd(r < 85, (r < 30) ? 1 : (r < 50) ? 2 : (r < 62) ? 3 :
                         (r < 72) ? 4 : (r < 82) ? 5 : $urandom_range(6, 7) % 8,
                $urandom_range(0, MASK), $urandom_range(0, MASK));
        end
        idle(); idle();
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
            $finish;
        end
    end
endmodule